// File: doc/BRIEF.md
# DMA Channel Completion Reporter

This block reports completions for a multi-channel DMA engine. The engine's data movers give it a pulse when a channel's command list ends, normally or with an error. The block then keeps a result word for that channel. The word carries a valid flag and one bit for each cause. While a channel holds an unread result, the block sets that channel's bit in an interrupt status vector. It raises a single interrupt line when an enabled channel has a result waiting.

Software uses a plain register port that has one read strobe and one write strobe. Through this port it reads a channel's result, its status word and the interrupt vector, and it programs a two-bit configuration for each channel. Reading a result removes it from the channel. Each channel holds one extra result in a pending slot, so a second completion that arrives before the first result is read is kept. Writing a channel's flush address aborts the transfer in progress. The block gives the engine a one-cycle abort pulse and, when flush reporting is enabled, posts a flushed result.

The address is split into a three-bit group field above the channel number. The groups are: 0 result (read pops), 1 status, 2 configuration, 3 flush, and 4 interrupt vector (channel bits ignored). Read data comes back one cycle after the read strobe, marked by `reg_rvalid`. The register port has no back-pressure: every strobe is accepted in its cycle.

Top module: `dma_result_reporter`

## Requirements
- R1: A result word has bit 31 = valid, bit 3 = error, bit 2 = flushed, bit 1 = normal completion, and all other bits zero. An empty result reads as all zeros.
- R2: A `ch_done`/`ch_err` pulse on a channel posts a result the following cycle. A read strobe returns data in `reg_rdata` with `reg_rvalid` high exactly one cycle later. Without a read, `reg_rvalid` is low and `reg_rdata` is zero.
- R3: The status word (group 1) has bit 1 set when the channel has a result available and all other bits zero.
- R4: Reading a channel's result (group 0) removes it. From the next cycle the status bit, the vector bit and the interrupt contribution of that channel clear, unless a pending result takes its place.
- R5: A result that arrives while one is waiting is kept in a one-deep pending slot and is returned by the next read. A further result that arrives while both slots are full is discarded.
- R6: The interrupt vector (group 4) has bit i set exactly when channel i has a result available. Bits at and above the channel count are zero.
- R7: `irq` is high when any channel with a result available has configuration bit 0 (interrupt enable) set. Writing zero to a channel's configuration masks it without dropping its result.
- R8: The configuration word (group 2) stores bit 0 (interrupt enable) and bit 1 (flush-report enable). It reads back with all other bits zero.
- R9: A write of any value to a busy channel's flush address (group 3) pulses that channel's `flush_abort` bit for one cycle in the next cycle. It posts a result with valid and flushed bits only if flush reporting is enabled. A completion pulse on that channel in the same cycle is discarded.
- R10: A flush written to a channel whose `ch_busy` is low produces no abort pulse and no result.
- R11: After reset, no channel holds a result, every configuration is zero, and `irq`, `reg_rvalid`, `reg_rdata` and `flush_abort` are zero.
- R12: Reading an empty result changes nothing. Writes to the result, status and vector groups have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_done | input | NUM_CH | Per-channel normal completion pulse |
| ch_err | input | NUM_CH | Per-channel error completion pulse |
| ch_busy | input | NUM_CH | Channel currently runs a command list |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | CH_W+3 | Group field above channel number |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after strobe |
| reg_rdata | output | 32 | Read data |
| flush_abort | output | NUM_CH | One-cycle abort request to the engine |
| irq | output | 1 | Aggregate interrupt |

## Verification
The hardest state to reach is a channel with both slots full, where a pop and a new completion land in the same cycle. In that state the pending word must move forward and the newcomer must fill the freed slot. A flush that coincides with a completion pulse is the other rare case. The directed phase builds these states with back-to-back pulses on one channel and single-cycle flush writes. A long random phase with dense completion pulses and frequent reads then drives every channel through full, popped and refilled states, against a queue-based model.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  localparam int RES_W     = 32;
  localparam int GRP_W     = 3;
  localparam int BIT_VALID = 31;
  localparam int BIT_ERR   = 3;
  localparam int BIT_FLUSH = 2;
  localparam int BIT_DONE  = 1;
  localparam int BIT_AVAIL = 1;
  localparam int CFG_IE    = 0;
  localparam int CFG_FR    = 1;

  typedef enum logic [GRP_W-1:0] {
    GRP_RESULT = 3'd0,
    GRP_STATUS = 3'd1,
    GRP_CFG    = 3'd2,
    GRP_FLUSH  = 3'd3,
    GRP_IRQVEC = 3'd4
  } grp_e;

  typedef struct packed {
    logic err;
    logic flush;
    logic done;
  } cause_t;

  function automatic logic [RES_W-1:0] encode_result(input logic vld, input cause_t c);
    logic [RES_W-1:0] w;
    w = '0;
    w[BIT_VALID] = vld;
    w[BIT_ERR]   = vld & c.err;
    w[BIT_FLUSH] = vld & c.flush;
    w[BIT_DONE]  = vld & c.done;
    return w;
  endfunction
endpackage

// File: rtl/dma_rr_slot.sv
module dma_rr_slot
  import dma_rr_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  cause_t push_cause,
  input  logic   pop,
  output logic   head_valid,
  output cause_t head_cause
);
  cause_t mem_q [DEPTH];
  cause_t mem_sh[DEPTH];
  cause_t mem_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_sh, vld_d;
  logic placed;

  // shift out the head on a pop, then place a new entry at the first free slot
  always_comb begin
    mem_sh = mem_q;
    vld_sh = vld_q;
    if (pop && vld_q[0]) begin
      for (int i = 0; i < DEPTH-1; i++) mem_sh[i] = mem_q[i+1];
      mem_sh[DEPTH-1] = '0;
      vld_sh = vld_q >> 1;
    end
    mem_d  = mem_sh;
    vld_d  = vld_sh;
    placed = 1'b0;
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!placed && !vld_sh[i]) begin
          mem_d[i] = push_cause;
          vld_d[i] = 1'b1;
          placed   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign head_valid = vld_q[0];
  assign head_cause = mem_q[0];
endmodule

// File: rtl/dma_rr_regif.sv
module dma_rr_regif
  import dma_rr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int ADDR_W = CH_W + GRP_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [RES_W-1:0]              wdata,
  input  logic [NUM_CH-1:0]             head_valid,
  input  logic [NUM_CH-1:0][RES_W-1:0]  head_word,
  output logic [NUM_CH-1:0]             cfg_ie,
  output logic [NUM_CH-1:0]             cfg_fr,
  output logic [NUM_CH-1:0]             pop,
  output logic [NUM_CH-1:0]             flush_req,
  output logic                          rvalid,
  output logic [RES_W-1:0]              rdata
);
  grp_e            grp;
  logic [CH_W-1:0] ch;
  logic            ch_ok;
  logic [RES_W-1:0] rd_mux;
  logic            unused_wdata_hi;

  assign grp   = grp_e'(addr[ADDR_W-1:CH_W]);
  assign ch    = addr[CH_W-1:0];
  assign ch_ok = ({1'b0, ch} < (CH_W+1)'(NUM_CH));
  assign unused_wdata_hi = ^wdata[RES_W-1:2];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit          = ch_ok && (ch == CH_W'(c));
    assign pop[c]       = rd_en && (grp == GRP_RESULT) && hit && head_valid[c];
    assign flush_req[c] = wr_en && (grp == GRP_FLUSH) && hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_ie[c] <= 1'b0;
        cfg_fr[c] <= 1'b0;
      end else if (wr_en && (grp == GRP_CFG) && hit) begin
        cfg_ie[c] <= wdata[CFG_IE];
        cfg_fr[c] <= wdata[CFG_FR];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (grp)
      GRP_RESULT: if (ch_ok) rd_mux = head_word[ch];
      GRP_STATUS: if (ch_ok) rd_mux[BIT_AVAIL] = head_valid[ch];
      GRP_CFG: if (ch_ok) begin
        rd_mux[CFG_IE] = cfg_ie[ch];
        rd_mux[CFG_FR] = cfg_fr[ch];
      end
      GRP_IRQVEC: rd_mux[NUM_CH-1:0] = head_valid;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/dma_rr_irq.sv
module dma_rr_irq #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] avail,
  input  logic [NUM_CH-1:0] enable,
  output logic              irq
);
  assign irq = |(avail & enable);
endmodule

// File: rtl/dma_result_reporter.sv
module dma_result_reporter
  import dma_rr_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int HOLD_DEPTH = 2,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W    = CH_W + GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_err,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [RES_W-1:0]  reg_wdata,
  output logic              reg_rvalid,
  output logic [RES_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] flush_abort,
  output logic              irq
);
  logic [NUM_CH-1:0]            head_valid;
  logic [NUM_CH-1:0][RES_W-1:0] head_word;
  logic [NUM_CH-1:0]            cfg_ie, cfg_fr, pop, flush_req, flush_hit;

  dma_rr_regif #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) regif_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .head_valid(head_valid),
    .head_word(head_word), .cfg_ie(cfg_ie), .cfg_fr(cfg_fr), .pop(pop),
    .flush_req(flush_req), .rvalid(reg_rvalid), .rdata(reg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic   push;
    cause_t cause, head_cause;

    // a flush on a busy channel overrides any completion seen in that cycle
    assign flush_hit[c] = flush_req[c] & ch_busy[c];
    always_comb begin
      if (flush_hit[c]) begin
        push  = cfg_fr[c];
        cause = '{err: 1'b0, flush: 1'b1, done: 1'b0};
      end else begin
        push  = ch_done[c] | ch_err[c];
        cause = '{err: ch_err[c], flush: 1'b0, done: ch_done[c]};
      end
    end

    dma_rr_slot #(.DEPTH(HOLD_DEPTH)) slot_i (
      .clk(clk), .rst_n(rst_n), .push(push), .push_cause(cause),
      .pop(pop[c]), .head_valid(head_valid[c]), .head_cause(head_cause)
    );

    assign head_word[c] = encode_result(head_valid[c], head_cause);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flush_abort <= '0;
    else        flush_abort <= flush_hit;
  end

  dma_rr_irq #(.NUM_CH(NUM_CH)) irq_i (
    .avail(head_valid), .enable(cfg_ie), .irq(irq)
  );
endmodule

// File: rtl/dma_result_reporter_chk.sv
module dma_result_reporter_chk #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_busy,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rvalid,
  input logic [31:0]       reg_rdata,
  input logic [NUM_CH-1:0] flush_abort,
  input logic              irq,
  input logic [NUM_CH-1:0] head_valid,
  input logic [NUM_CH-1:0] cfg_ie
);
  localparam int CH_W = ADDR_W - 3;
  logic [2:0] grp;
  assign grp = reg_addr[ADDR_W-1:CH_W];

  assert_rvalid_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);
  assert_no_idle_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> (!reg_rvalid && reg_rdata == 32'h0));
  assert_result_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && grp == 3'd0) |=>
      ((reg_rdata & ~32'h8000_000E) == 32'h0 && (reg_rdata == 32'h0 || reg_rdata[31])));
  assert_status_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && grp == 3'd1) |=> ((reg_rdata & ~32'h2) == 32'h0));
  assert_cfg_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && grp == 3'd2) |=> (reg_rdata[31:2] == 30'h0));
  assert_irqvec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && grp == 3'd4) |=> (reg_rdata[NUM_CH-1:0] == $past(head_valid)));
  assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_abort));
  assert_abort_busy_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_abort != '0) |-> ((flush_abort & ~$past(ch_busy)) == '0));
  assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((head_valid & cfg_ie) != '0));
endmodule

bind dma_result_reporter dma_result_reporter_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_busy(ch_busy), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
  .flush_abort(flush_abort), .irq(irq), .head_valid(head_valid), .cfg_ie(cfg_ie)
);

// File: tb/dma_result_reporter_tb_top.sv
module dma_result_reporter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 16;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] ch_done = '0, ch_err = '0, ch_busy = '0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_rvalid, irq;
  logic [31:0] reg_rdata;
  logic [NUM_CH-1:0] flush_abort;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  dma_result_reporter #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_done(ch_done), .ch_err(ch_err), .ch_busy(ch_busy),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .flush_abort(flush_abort), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int unsigned mq[NUM_CH][$];
  logic [1:0]  mcfg[NUM_CH];
  logic [31:0] m_rdata = '0;
  logic        m_rvalid = 1'b0;
  logic [NUM_CH-1:0] m_abort = '0;
  int g_m, c_m;

  function automatic bit m_irq();
    for (int i = 0; i < NUM_CH; i++)
      if (mq[i].size() > 0 && mcfg[i][0]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin mq[i].delete(); mcfg[i] = 2'b00; end
      m_rdata = '0; m_rvalid = 1'b0; m_abort = '0;
    end else begin
      g_m = int'(reg_addr[6:4]);
      c_m = int'(reg_addr[3:0]);
      m_rvalid = reg_rd_en;
      m_rdata  = '0;
      if (reg_rd_en) begin
        case (g_m)
          0: if (mq[c_m].size() > 0) m_rdata = mq[c_m][0];
          1: m_rdata = (mq[c_m].size() > 0) ? 32'h2 : 32'h0;
          2: m_rdata = {30'h0, mcfg[c_m]};
          4: for (int i = 0; i < NUM_CH; i++) m_rdata[i] = (mq[i].size() > 0);
          default: m_rdata = '0;
        endcase
      end
      for (int i = 0; i < NUM_CH; i++) begin
        bit fl;
        int unsigned w;
        if (reg_rd_en && g_m == 0 && c_m == i && mq[i].size() > 0) void'(mq[i].pop_front());
        fl = reg_wr_en && g_m == 3 && c_m == i && ch_busy[i];
        m_abort[i] = fl;
        w = 0;
        if (fl) begin
          if (mcfg[i][1]) w = 32'h8000_0004;
        end else if (ch_done[i] || ch_err[i]) begin
          w = 32'h8000_0000 | (ch_err[i] ? 32'h8 : 32'h0) | (ch_done[i] ? 32'h2 : 32'h0);
        end
        if (w != 0 && mq[i].size() < 2) mq[i].push_back(w);
      end
      if (reg_wr_en && g_m == 2) mcfg[c_m] = reg_wdata[1:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 rvalid", {31'h0, reg_rvalid}, {31'h0, m_rvalid});
      chk("R2 rdata", reg_rdata, m_rdata);
      chk("R7 irq", {31'h0, irq}, {31'h0, m_irq()});
      chk("R9 flush_abort", {16'h0, flush_abort}, {16'h0, m_abort});
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [6:0] adr(input int g, input int c);
    return {g[2:0], c[3:0]};
  endfunction

  task automatic do_rd(input logic [6:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic do_wr(input logic [6:0] a, input logic [31:0] v);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_CH-1:0] dn, input logic [NUM_CH-1:0] er);
    ch_done = dn; ch_err = er;
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq after reset", {31'h0, irq}, 32'h0);
    chk("R11 rdata after reset", reg_rdata, 32'h0);
    chk("R11 abort after reset", {16'h0, flush_abort}, 32'h0);
    do_rd(adr(2, 0), d); chk("R11 cfg cleared", d, 32'h0);
    do_rd(adr(4, 0), d); chk("R11 vector empty", d, 32'h0);

    // R8 config storage
    do_wr(adr(2, 3), 32'h3);
    do_rd(adr(2, 3), d); chk("R8 cfg readback", d, 32'h3);
    do_wr(adr(2, 3), 32'hFFFF_FFFF);
    do_rd(adr(2, 3), d); chk("R8 cfg upper bits zero", d, 32'h3);

    // R1/R2/R3/R4/R6/R7 single completion
    pulse(16'h0008, 16'h0);
    do_rd(adr(1, 3), d); chk("R3 status available", d, 32'h2);
    do_rd(adr(4, 0), d); chk("R6 vector bit 3", d, 32'h8);
    chk("R7 irq with enable", {31'h0, irq}, 32'h1);
    do_rd(adr(0, 3), d); chk("R1 done word", d, 32'h8000_0002);
    do_rd(adr(1, 3), d); chk("R4 status cleared after pop", d, 32'h0);
    chk("R4 irq cleared after pop", {31'h0, irq}, 32'h0);

    // R1/R7 error with done on masked channel 5
    pulse(16'h0020, 16'h0020);
    chk("R7 masked channel no irq", {31'h0, irq}, 32'h0);
    do_rd(adr(4, 0), d); chk("R6 vector bit 5", d, 32'h20);
    do_rd(adr(0, 5), d); chk("R1 error word", d, 32'h8000_000A);

    // R5 pending slot and overflow drop
    pulse(16'h0008, 16'h0);
    pulse(16'h0, 16'h0008);
    pulse(16'h0008, 16'h0);
    do_rd(adr(0, 3), d); chk("R5 first result", d, 32'h8000_0002);
    do_rd(adr(0, 3), d); chk("R5 pending result", d, 32'h8000_0008);
    do_rd(adr(0, 3), d); chk("R5 third dropped", d, 32'h0);
    do_rd(adr(0, 3), d); chk("R12 empty read", d, 32'h0);

    // R5 pop and new completion in the same cycle with both slots full
    pulse(16'h0008, 16'h0);
    pulse(16'h0, 16'h0008);
    ch_done = 16'h0008;
    do_rd(adr(0, 3), d); ch_done = '0;
    chk("R5 head under simultaneous pop", d, 32'h8000_0002);
    do_rd(adr(0, 3), d); chk("R5 shifted pending", d, 32'h8000_0008);
    do_rd(adr(0, 3), d); chk("R5 refilled slot", d, 32'h8000_0002);

    // R9 flush with report enabled, done in same cycle discarded
    ch_busy = 16'h0008;
    ch_done = 16'h0008;
    do_wr(adr(3, 3), 32'h0);
    ch_done = '0;
    chk("R9 abort pulse", {16'h0, flush_abort}, 32'h8);
    do_rd(adr(0, 3), d); chk("R9 flushed word", d, 32'h8000_0004);
    do_rd(adr(0, 3), d); chk("R9 coincident done discarded", d, 32'h0);

    // R9 flush with report disabled
    do_wr(adr(2, 3), 32'h1);
    do_wr(adr(3, 3), 32'h1234);
    chk("R9 abort without report", {16'h0, flush_abort}, 32'h8);
    do_rd(adr(0, 3), d); chk("R9 no flushed word when disabled", d, 32'h0);
    ch_busy = '0;

    // R10 flush on idle channel
    do_wr(adr(2, 6), 32'h3);
    do_wr(adr(3, 6), 32'h0);
    chk("R10 no abort when idle", {16'h0, flush_abort}, 32'h0);
    do_rd(adr(1, 6), d); chk("R10 no result when idle", d, 32'h0);

    // R12 writes to read-only groups ignored
    pulse(16'h0004, 16'h0);
    do_wr(adr(0, 2), 32'hFFFF_FFFF);
    do_wr(adr(1, 2), 32'hFFFF_FFFF);
    do_wr(adr(4, 2), 32'hFFFF_FFFF);
    do_rd(adr(0, 2), d); chk("R12 result survives writes", d, 32'h8000_0002);

    // R7 masking with pending result
    pulse(16'h0008, 16'h0);
    chk("R7 irq enabled ch3", {31'h0, irq}, 32'h1);
    do_wr(adr(2, 3), 32'h0);
    chk("R7 irq masked by zero cfg", {31'h0, irq}, 32'h0);
    do_rd(adr(1, 3), d); chk("R7 result kept while masked", d, 32'h2);
    do_rd(adr(0, 3), d);

    // random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      ch_done   = NUM_CH'($urandom & $urandom & $urandom);
      ch_err    = NUM_CH'($urandom & $urandom & $urandom & $urandom);
      ch_busy   = NUM_CH'($urandom);
      reg_rd_en = ($urandom_range(0, 2) != 0);
      reg_wr_en = ($urandom_range(0, 3) == 0);
      reg_addr  = {3'($urandom_range(0, 5)), 4'($urandom)};
      reg_wdata = $urandom;
      @(negedge clk);
    end
    ch_done = '0; ch_err = '0; ch_busy = '0; reg_rd_en = 1'b0; reg_wr_en = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule